// File: doc/BRIEF.md
# Supply Supervisor Reset Controller

This block generates the system reset for a processor supervisor. It combines three reset causes into one open-drain reset output. The first is a synchronous "supply above trip" flag from an external comparator. The second is a power-on hold interval. The third is a watchdog that watches the data line of a 2-wire serial bus and times out when that line stops changing.

A three-bit configuration register holds the watchdog enable and a 2-bit period select. Writes to this register arrive on a simple write port and are refused while the write-protect input is high. The register value is always visible on `cfg_q`.

The reset output is modelled as an output enable, `rst_oe`, plus a constant drive level, `rst_lvl`. When `rst_oe` is high the pad drives `rst_lvl`. Otherwise the pad is released to an external pull. The parameter `ACTIVE_HIGH` chooses between the active-low and active-high variants.

Top module: `supply_supervisor`

## Requirements
- R1: In any cycle where `supply_ok` is low, `rst_oe` is high in that same cycle.
- R2: After `supply_ok` returns high, `rst_oe` stays high until `supply_ok` has been sampled high on POR_CYCLES consecutive rising clock edges, and is low after that edge.
- R3: After `rst_n` is released with `supply_ok` high, `rst_oe` is high for exactly POR_CYCLES clock edges and then goes low.
- R4: While the watchdog is enabled, `rst_oe` rises after the synchronized data line has shown no edge for the selected number of consecutive cycles T. Counted from the clock edge that follows the last change of `sda_in`, the reset is asserted after edge 3+T and not after edge 2+T.
- R5: `cfg_q[2:1]` selects the timeout period: value 0 gives TO_0, 1 gives TO_1, 2 gives TO_2 and 3 gives TO_3.
- R6: `cfg_q` takes the value of `cfg_wdata` on a clock edge with `cfg_we` high and `wp` low. On an edge with `wp` high, `cfg_q` does not change.
- R7: `rst_lvl` is the constant level `ACTIVE_HIGH`; the asserting level is driven only while `rst_oe` is high.
- R8: `sda_in` passes through two synchronizing flops. Any edge on the synchronized line clears the watchdog count.
- R9: With `cfg_q[0]` (the enable bit) at 0, the watchdog count is held at zero and never causes a reset.
- R10: A watchdog timeout asserts reset for exactly POR_CYCLES cycles. The watchdog count then restarts from zero, so with a still line the next timeout follows T cycles after release.
- R11: A supply drop at any point in a reset interval restarts the full POR_CYCLES interval once the supply is back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset of the logic, active low |
| supply_ok | input | 1 | Synchronous flag: supply above trip level |
| sda_in | input | 1 | Serial bus data line (asynchronous) |
| wp | input | 1 | Write protect for the configuration register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration write data: bit 0 enable, bits 2:1 period select |
| cfg_q | output | 3 | Current configuration register |
| rst_oe | output | 1 | Reset pad drive enable (1 = reset asserted) |
| rst_lvl | output | 1 | Level driven while `rst_oe` is high |

## Verification
A supply drop shows on `rst_oe` in the same cycle, with no delay.

The power-on release and the timeout-driven release both come POR_CYCLES edges after their trigger. A watchdog reset appears 3+T edges after the last change of `sda_in`: two edges are spent in the synchronizer and one clears the count. A configuration write is visible on `cfg_q` one edge later.

The bench drives every input at a falling edge. It then advances a precise number of rising edges, and samples at the next falling edge both the last cycle before each change is due and the first cycle after it. It sweeps all four period selects in this way.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef struct packed {
    logic [1:0] sel;
    logic       en;
  } sup_cfg_t;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sup_ctrl_reg.sv
module sup_ctrl_reg
  import sup_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wp,
  input  logic     we,
  input  sup_cfg_t wdata,
  output sup_cfg_t q
);
  logic wr_ok;
  assign wr_ok = we && !wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr_ok) q <= wdata;
  end

  a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wp) |=> $stable(q));
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wp) |=> (q == $past(wdata)));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int unsigned TO_0 = 6250000,
  parameter int unsigned TO_1 = 25000000,
  parameter int unsigned TO_2 = 100000000,
  parameter int unsigned TO_3 = 200000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       hold,
  output logic       fire
);
  localparam int unsigned TMAX = max4(TO_0, TO_1, TO_2, TO_3);
  localparam int unsigned WW   = $clog2(TMAX + 1);

  function automatic logic [WW-1:0] period_of(input logic [1:0] s);
    case (s)
      2'd0:    return WW'(TO_0);
      2'd1:    return WW'(TO_1);
      2'd2:    return WW'(TO_2);
      default: return WW'(TO_3);
    endcase
  endfunction

  logic          s1, s2, s3;
  logic          sda_edge;
  logic [WW-1:0] wcnt;
  logic [WW-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= sda_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign sda_edge = s2 ^ s3;
  assign lim      = period_of(sel);
  assign fire     = en && !hold && !sda_edge && (wcnt >= lim - WW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wcnt <= '0;
    else if (!en || hold)       wcnt <= '0;
    else if (sda_edge || fire)  wcnt <= '0;
    else                        wcnt <= wcnt + WW'(1);
  end

  a_r8_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sda_edge |=> (wcnt == '0));
  a_r9_off_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (wcnt == '0));
  a_r9_off_never_fires: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !fire);
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (wcnt == '0));
endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
  parameter int unsigned POR_CYCLES = 31250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic wd_fire,
  output logic in_reset
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          done;

  assign done = (cnt == CW'(POR_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reset <= 1'b1;
      cnt      <= '0;
    end else if (!supply_ok || wd_fire) begin
      in_reset <= 1'b1;
      cnt      <= '0;
    end else if (in_reset) begin
      if (done) begin
        in_reset <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  a_r1_brownout_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (in_reset && cnt == '0));
  a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_reset) |-> $past(supply_ok));
  a_r10_fire_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> (in_reset && cnt == '0));
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned POR_CYCLES  = 31250000,
  parameter int unsigned TO_0        = 6250000,
  parameter int unsigned TO_1        = 25000000,
  parameter int unsigned TO_2        = 100000000,
  parameter int unsigned TO_3        = 200000000,
  parameter bit          ACTIVE_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       sda_in,
  input  logic       wp,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wdata,
  output logic [2:0] cfg_q,
  output logic       rst_oe,
  output logic       rst_lvl
);
  sup_cfg_t cfg;
  logic     wd_fire;
  logic     in_reset;

  sup_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wp    (wp),
    .we    (cfg_we),
    .wdata (sup_cfg_t'(cfg_wdata)),
    .q     (cfg)
  );

  sup_wdog #(.TO_0(TO_0), .TO_1(TO_1), .TO_2(TO_2), .TO_3(TO_3)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .sda_in (sda_in),
    .en     (cfg.en),
    .sel    (cfg.sel),
    .hold   (rst_oe),
    .fire   (wd_fire)
  );

  sup_rst_timer #(.POR_CYCLES(POR_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .wd_fire   (wd_fire),
    .in_reset  (in_reset)
  );

  assign cfg_q   = cfg;
  assign rst_oe  = in_reset || !supply_ok;
  assign rst_lvl = ACTIVE_HIGH;

  a_r11_recover_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_ok) |-> rst_oe);
  a_r4_fire_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> rst_oe);
endmodule

// File: tb/supply_supervisor_bench.sv
module supply_supervisor_bench;
  localparam int POR = 12;
  localparam int T0 = 5, T1 = 9, T2 = 13, T3 = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b1;
  logic       sda_in = 1'b1;
  logic       wp = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = 3'd0;
  logic [2:0] cfg_q;
  logic       rst_oe;
  logic       rst_lvl;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  supply_supervisor #(.POR_CYCLES(POR), .TO_0(T0), .TO_1(T1), .TO_2(T2), .TO_3(T3),
                      .ACTIVE_HIGH(1'b0)) u_supply_supervisor (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sda_in(sda_in), .wp(wp),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .rst_oe(rst_oe),
    .rst_lvl(rst_lvl)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] d);
    cfg_wdata = d;
    cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  function automatic int period(input int s);
    return (s == 0) ? T0 : (s == 1) ? T1 : (s == 2) ? T2 : T3;
  endfunction

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R3 reset state oe", rst_oe, 1);
    chk("R6 reset cfg", cfg_q, 0);
    chk("R7 level", rst_lvl, 0);
    rst_n = 1'b1;
    tick(POR - 1);
    chk("R3 held", rst_oe, 1);
    tick(1);
    chk("R3 released", rst_oe, 0);

    // brown-out
    supply_ok = 1'b0;
    #1;
    chk("R1 immediate", rst_oe, 1);
    tick(3);
    chk("R1 low held", rst_oe, 1);
    supply_ok = 1'b1;
    tick(POR - 1);
    chk("R2 held", rst_oe, 1);
    tick(1);
    chk("R2 released", rst_oe, 0);

    // drop inside the interval
    supply_ok = 1'b0;
    tick(2);
    supply_ok = 1'b1;
    tick(5);
    supply_ok = 1'b0;
    #1;
    chk("R11 drop mid", rst_oe, 1);
    tick(1);
    supply_ok = 1'b1;
    tick(POR - 1);
    chk("R11 full restart", rst_oe, 1);
    tick(1);
    chk("R11 released", rst_oe, 0);

    // write protect
    wp = 1'b1;
    wr(3'b111);
    chk("R6 wp ignored", cfg_q, 0);
    tick(3 * T3);
    chk("R6 wp no watchdog", rst_oe, 0);
    wp = 1'b0;
    wr(3'b100);
    chk("R6 write lands", cfg_q, 4);

    // disabled watchdog, still line
    tick(3 * T3);
    chk("R9 disabled", rst_oe, 0);

    // sweep of the period select
    for (int s = 0; s < 4; s++) begin
      int lim;
      lim = period(s);
      wr(3'((s << 1) | 1));
      chk("R5 cfg readback", cfg_q, (s << 1) | 1);
      for (int k = 0; k < 4; k++) begin
        sda_in = ~sda_in;
        tick(1);
      end
      tick(1 + lim);
      chk($sformatf("R4 R8 not yet sel=%0d", s), rst_oe, 0);
      tick(1);
      chk($sformatf("R4 R5 timeout sel=%0d", s), rst_oe, 1);
      tick(POR - 1);
      chk("R10 pulse held", rst_oe, 1);
      tick(1);
      chk("R10 pulse end", rst_oe, 0);
      tick(lim - 1);
      chk("R10 restart not yet", rst_oe, 0);
      tick(1);
      chk("R10 restart fires", rst_oe, 1);
      wr(3'b000);
      tick(POR);
      chk("R9 disable releases", rst_oe, 0);
      tick(2 * T3);
      chk("R9 stays quiet", rst_oe, 0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule